// File: doc/BRIEF.md
# Sequential Multiply Unit with High/Low Product Registers

This unit serves a 32-bit processor datapath as its multiplier. A multiply command takes two source operands. The unit forms the full double-width product and stores it in two architecturally visible registers: a high-half register and a low-half register. Later move commands read either half back onto a single read port. A three-operand form also exists. It multiplies as a signed multiply does and also hands back the low half of the product on the read port as soon as the product is ready.

The product comes from a shift-and-add engine that takes one step per multiplier bit. While it runs, the unit lowers its ready signal, so a move issued right behind a multiply stalls until the new product has been written. Signed multiplies take the magnitudes of the operands and negate the result in a separate finishing cycle. After each product is written, an overflow flag shows whether the result fits in a single word. Unsigned products are judged on the high half. Signed products are judged on whether the high half is only the sign extension of the low half.

The control state machine has three states. S_IDLE accepts commands. S_RUN waits for the shift-add engine. S_FIX applies the sign correction and writes the registers. There are three transitions. S_IDLE to S_RUN is taken when a multiply is accepted. S_RUN to S_FIX is taken when the engine reports done. S_FIX returns to S_IDLE unconditionally.

Top module: `hilo_mul_unit`

## Requirements
- R1: After reset the high and low registers are zero, `ovf` is 0, `cmd_ready` is 1 and `busy` is 0.
- R2: Command code 2 (unsigned multiply) writes the unsigned 2W-bit product of `src_a` and `src_b`, with bits 2W-1..W going to the high register and bits W-1..0 going to the low register.
- R3: Command code 1 (signed multiply) writes the two's-complement 2W-bit product of `src_a` and `src_b` into the high and low registers in the same split.
- R4: Command code 3 (move high) returns the high register on `rd_data`, and command code 4 (move low) returns the low register. In both cases `rd_valid` is 1 in the cycle after the command is accepted.
- R5: Command code 5 (three-operand multiply) multiplies signed, writes both registers, and returns the low W bits of the product on `rd_data` with `rd_valid` at 1 once the product is written.
- R6: After an unsigned multiply, `ovf` is 1 exactly when the high register is nonzero.
- R7: After a signed multiply (code 1 or 5), `ovf` is 1 exactly when the high register differs from W copies of bit W-1 of the low register.
- R8: After the clock edge that accepts any multiply, `cmd_ready` stays 0 (and `busy` stays 1) for exactly W+2 cycles. A move held at the port during that time is accepted afterwards and returns the new product.
- R9: The high register, the low register and `ovf` change only when a multiply completes. Moves and the codes 0, 6 and 7 leave them untouched.
- R10: `rd_valid` is 1 only in the cycle after an accepted move, or in the cycle in which a three-operand product is written. Codes 0, 6, 7, 1 and 2 never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented |
| cmd_op | input | 3 | Command code: 0 none, 1 signed, 2 unsigned, 3 move high, 4 move low, 5 three-operand, 6 and 7 none |
| src_a | input | W (32) | Multiplicand operand |
| src_b | input | W (32) | Multiplier operand |
| cmd_ready | output | 1 | Command accepted on this edge when `cmd_valid` is 1 |
| busy | output | 1 | A multiply is in progress |
| rd_valid | output | 1 | `rd_data` holds a returned value |
| rd_data | output | W (32) | Read port for moves and the three-operand result |
| ovf | output | 1 | The last written product does not fit in W bits |

## Verification
Assertions check several rules on every cycle. A move returns the register it names one cycle later. The registers hold between writes. The overflow flag matches the written halves under both signed and unsigned rules. The read port is raised only by a move or a three-operand completion. The engine's step counter stays in range and its done pulse lasts one cycle. Only the bench's scenarios show that the stored products are arithmetically correct for mixed signs, the most negative operand and full-scale unsigned values. They also show that the stall lasts exactly W+2 cycles, and that a move queued behind a multiply returns the fresh product rather than the old one.

// File: rtl/prodreg_pkg.sv
package prodreg_pkg;
    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_MULS  = 3'd1,
        OP_MULU  = 3'd2,
        OP_RDHI  = 3'd3,
        OP_RDLO  = 3'd4,
        OP_MULLO = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_FIX  = 2'd2
    } state_e;
endpackage

// File: rtl/operand_cond.sv
module operand_cond #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         is_signed,
    output logic [W-1:0] a_mag,
    output logic [W-1:0] b_mag,
    output logic         negate
);
    logic [W-1:0] src [2];
    logic [W-1:0] mag [2];

    assign src[0] = a;
    assign src[1] = b;

    for (genvar i = 0; i < 2; i++) begin : g_mag
        always_comb begin
            if (is_signed && src[i][W-1]) mag[i] = W'(~src[i] + 1'b1);
            else                          mag[i] = src[i];
        end
    end

    assign a_mag  = mag[0];
    assign b_mag  = mag[1];
    assign negate = is_signed && (a[W-1] ^ b[W-1]);
endmodule

// File: rtl/shift_add_core.sv
module shift_add_core #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] product
);
    localparam int CW = $clog2(W) + 1;

    logic [2*W-1:0] acc_q;
    logic [W-1:0]   mcand_q;
    logic [CW-1:0]  cnt_q;
    logic           run_q;
    logic           done_q;
    logic [W:0]     sum;
    logic [2*W-1:0] step;

    always_comb begin
        sum  = {1'b0, acc_q[2*W-1:W]} + (acc_q[0] ? {1'b0, mcand_q} : {(W+1){1'b0}});
        step = {sum, acc_q[W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            mcand_q <= '0;
            cnt_q   <= '0;
            run_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                acc_q   <= {{W{1'b0}}, mplier};
                mcand_q <= mcand;
                cnt_q   <= '0;
                run_q   <= 1'b1;
            end else if (run_q) begin
                acc_q <= step;
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CW'(W - 1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy    = run_q;
    assign done    = done_q;
    assign product = acc_q;

    // R8: step counter never passes the operand width
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q < CW'(W)));
    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R8: a new start never lands on a running engine
    p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !run_q);
endmodule

// File: rtl/result_cond.sv
module result_cond #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] raw,
    input  logic           negate,
    input  logic           is_signed,
    output logic [W-1:0]   hi,
    output logic [W-1:0]   lo,
    output logic           ovf
);
    logic [2*W-1:0] fixed;

    always_comb begin
        fixed = negate ? (2*W)'(~raw + 1'b1) : raw;
        hi    = fixed[2*W-1:W];
        lo    = fixed[W-1:0];
        if (is_signed) ovf = (hi != {W{lo[W-1]}});
        else           ovf = (hi != '0);
    end
endmodule

// File: rtl/hilo_mul_unit.sv
module hilo_mul_unit
    import prodreg_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_valid,
    input  logic [2:0]   cmd_op,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    output logic         cmd_ready,
    output logic         busy,
    output logic         rd_valid,
    output logic [W-1:0] rd_data,
    output logic         ovf
);
    op_e            op;
    state_e         state_q, state_d;
    logic           accept, is_mul, is_rd, mul_go, rd_go, op_signed;
    logic [W-1:0]   a_mag, b_mag;
    logic           neg_in;
    logic           core_busy, core_done;
    logic [2*W-1:0] core_prod;
    logic [2*W-1:0] raw_q;
    logic           sgn_q, low_q, neg_q;
    logic [W-1:0]   hi_q, lo_q, fix_hi, fix_lo;
    logic           ovf_q, fix_ovf;
    logic           rd_valid_q;
    logic [W-1:0]   rd_data_q;

    assign op        = op_e'(cmd_op);
    assign cmd_ready = (state_q == S_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign is_mul    = (op == OP_MULS) || (op == OP_MULU) || (op == OP_MULLO);
    assign is_rd     = (op == OP_RDHI) || (op == OP_RDLO);
    assign mul_go    = accept && is_mul;
    assign rd_go     = accept && is_rd;
    assign op_signed = (op != OP_MULU);

    operand_cond #(.W(W)) u_opc (
        .a         (src_a),
        .b         (src_b),
        .is_signed (op_signed),
        .a_mag     (a_mag),
        .b_mag     (b_mag),
        .negate    (neg_in)
    );

    shift_add_core #(.W(W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (mul_go),
        .mcand   (a_mag),
        .mplier  (b_mag),
        .busy    (core_busy),
        .done    (core_done),
        .product (core_prod)
    );

    result_cond #(.W(W)) u_res (
        .raw       (raw_q),
        .negate    (neg_q),
        .is_signed (sgn_q),
        .hi        (fix_hi),
        .lo        (fix_lo),
        .ovf       (fix_ovf)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (mul_go)    state_d = S_RUN;
            S_RUN:   if (core_done) state_d = S_FIX;
            S_FIX:                  state_d = S_IDLE;
            default:                state_d = S_IDLE;
        endcase
    end

    // outputs and architectural registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q      <= '0;
            sgn_q      <= 1'b0;
            low_q      <= 1'b0;
            neg_q      <= 1'b0;
            hi_q       <= '0;
            lo_q       <= '0;
            ovf_q      <= 1'b0;
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (mul_go) begin
                        sgn_q <= op_signed;
                        low_q <= (op == OP_MULLO);
                        neg_q <= neg_in;
                    end
                    if (rd_go) begin
                        rd_valid_q <= 1'b1;
                        rd_data_q  <= (op == OP_RDHI) ? hi_q : lo_q;
                    end
                end
                S_RUN: begin
                    if (core_done) raw_q <= core_prod;
                end
                S_FIX: begin
                    hi_q  <= fix_hi;
                    lo_q  <= fix_lo;
                    ovf_q <= fix_ovf;
                    if (low_q) begin
                        rd_valid_q <= 1'b1;
                        rd_data_q  <= fix_lo;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy     = (state_q != S_IDLE);
    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;
    assign ovf      = ovf_q;

    p_read_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && op == OP_RDHI) |=> (rd_valid && rd_data == $past(hi_q)));
    p_read_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && op == OP_RDLO) |=> (rd_valid && rd_data == $past(lo_q)));
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_FIX) |=> ({hi_q, lo_q, ovf_q} == $past({hi_q, lo_q, ovf_q})));
    p_ovf_unsigned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FIX && !sgn_q) |=> (ovf == (hi_q != '0)));
    p_ovf_signed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FIX && sgn_q) |=> (ovf == (hi_q != {W{lo_q[W-1]}})));
    p_busy_after_mul_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mul_go |=> (busy && !cmd_ready));
    p_run_has_engine_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN) |-> (core_busy || core_done));
    p_rd_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(rd_go) || $past(state_q == S_FIX && low_q)));
endmodule

// File: tb/hilo_mul_unit_bench.sv
module hilo_mul_unit_bench;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [2:0]   cmd_op = 3'd0;
    logic [W-1:0] src_a = '0;
    logic [W-1:0] src_b = '0;
    logic         cmd_ready, busy, rd_valid, ovf;
    logic [W-1:0] rd_data;

    int total = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    hilo_mul_unit #(.W(W)) u_hilo_mul_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .src_a(src_a), .src_b(src_b), .cmd_ready(cmd_ready), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data), .ovf(ovf)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // present a command at a negedge, wait for acceptance, return at the next negedge
    task automatic send(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                        output int waits);
        waits = 0;
        cmd_valid = 1'b1; cmd_op = op; src_a = a; src_b = b;
        while (!cmd_ready) begin
            @(negedge clk);
            waits++;
        end
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic rd(input logic [2:0] op, output logic [W-1:0] val, output logic vld);
        int w;
        send(op, '0, '0, w);
        vld = rd_valid;
        val = rd_data;
    endtask

    function automatic logic [63:0] ref_prod(input logic sgn, input logic [W-1:0] a,
                                             input logic [W-1:0] b);
        logic [63:0] ea, eb;
        ea = sgn ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
        eb = sgn ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
        return ea * eb;
    endfunction

    function automatic logic ref_ovf(input logic sgn, input logic [63:0] p);
        if (sgn) return p[63:32] != {W{p[31]}};
        return p[63:32] != '0;
    endfunction

    // multiply, then read both halves and the flag
    task automatic mul_and_check(input string tag, input logic [2:0] op,
                                 input logic [W-1:0] a, input logic [W-1:0] b);
        int w;
        logic [W-1:0] h, l;
        logic v;
        logic [63:0] p;
        p = ref_prod(op != 3'd2, a, b);
        send(op, a, b, w);
        rd(3'd3, h, v);
        chk({tag, " high"}, {32'd0, h}, {32'd0, p[63:32]});
        rd(3'd4, l, v);
        chk({tag, " low"}, {32'd0, l}, {32'd0, p[31:0]});
        chk({tag, op == 3'd2 ? " ovf R6" : " ovf R7"}, {63'd0, ovf}, {63'd0, ref_ovf(op != 3'd2, p)});
    endtask

    task automatic t_reset();
        logic [W-1:0] v32;
        logic v;
        chk("R1 ready", {63'd0, cmd_ready}, 64'd1);
        chk("R1 busy", {63'd0, busy}, 64'd0);
        chk("R1 ovf", {63'd0, ovf}, 64'd0);
        rd(3'd3, v32, v);
        chk("R1 high zero", {31'd0, v, v32}, {31'd0, 1'b1, 32'd0});
        rd(3'd4, v32, v);
        chk("R1 low zero", {31'd0, v, v32}, {31'd0, 1'b1, 32'd0});
    endtask

    task automatic t_unsigned();
        mul_and_check("R2 small", 3'd2, 32'h0000_0062, 32'h0000_0012);
        mul_and_check("R2 full", 3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        mul_and_check("R2 big", 3'd2, 32'h8000_0001, 32'h0000_0003);
    endtask

    task automatic t_signed();
        mul_and_check("R3 neg pos", 3'd1, 32'hFFFF_FFFE, 32'h0000_0003);
        mul_and_check("R3 neg neg", 3'd1, 32'hFFFF_FFF9, 32'hFFFF_FFFB);
        mul_and_check("R3 minval", 3'd1, 32'h8000_0000, 32'h8000_0000);
        mul_and_check("R3 zero neg", 3'd1, 32'h0000_0000, 32'h8000_0005);
        mul_and_check("R7 edge fit", 3'd1, 32'h8000_0000, 32'h0000_0001);
        mul_and_check("R7 edge over", 3'd1, 32'h4000_0000, 32'h0000_0002);
        mul_and_check("R6 unsigned edge", 3'd2, 32'h8000_0000, 32'h0000_0001);
    endtask

    task automatic t_lowform();
        int w, lat;
        logic [63:0] p;
        logic [W-1:0] h, l;
        logic v;
        p = ref_prod(1'b1, 32'hFFFF_FF00, 32'h0012_3456);
        send(3'd5, 32'hFFFF_FF00, 32'h0012_3456, w);
        lat = 0;
        while (!rd_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        chk("R5 low result", {32'd0, rd_data}, {32'd0, p[31:0]});
        chk("R5 latency", 64'(lat), 64'(W + 2));
        rd(3'd3, h, v);
        chk("R5 high written", {32'd0, h}, {32'd0, p[63:32]});
        rd(3'd4, l, v);
        chk("R5 low written", {32'd0, l}, {32'd0, p[31:0]});
        chk("R7 three-operand ovf", {63'd0, ovf}, {63'd0, ref_ovf(1'b1, p)});
    endtask

    task automatic t_stall();
        int w;
        logic [63:0] p;
        p = ref_prod(1'b0, 32'h1234_5678, 32'h9ABC_DEF0);
        send(3'd2, 32'h1234_5678, 32'h9ABC_DEF0, w);
        chk("R10 no read after multiply", {63'd0, rd_valid}, 64'd0);
        chk("R8 busy", {63'd0, busy}, 64'd1);
        send(3'd3, '0, '0, w);
        chk("R8 stall cycles", 64'(w), 64'(W + 2));
        chk("R8 fresh high", {31'd0, rd_valid, rd_data}, {31'd0, 1'b1, p[63:32]});
        send(3'd1, 32'hFFFF_FFFF, 32'h0000_0007, w);
        p = ref_prod(1'b1, 32'hFFFF_FFFF, 32'h0000_0007);
        send(3'd4, '0, '0, w);
        chk("R8 fresh low", {31'd0, rd_valid, rd_data}, {31'd0, 1'b1, p[31:0]});
    endtask

    task automatic t_hold();
        int w;
        logic [W-1:0] h0, l0, h, l;
        logic o0, v;
        logic [63:0] p;
        mul_and_check("R9 setup", 3'd1, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
        p = ref_prod(1'b1, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
        h0 = p[63:32]; l0 = p[31:0]; o0 = ovf;
        for (int k = 0; k < 3; k++) begin
            logic [2:0] code;
            code = (k == 0) ? 3'd0 : (k == 1) ? 3'd6 : 3'd7;
            send(code, 32'hDEAD_BEEF, 32'h0BAD_F00D, w);
            chk($sformatf("R10 no read for code %0d", code), {63'd0, rd_valid}, 64'd0);
            chk($sformatf("R9 not busy for code %0d", code), {63'd0, busy}, 64'd0);
        end
        rd(3'd3, h, v);
        rd(3'd3, h, v);
        chk("R9 high kept", {32'd0, h}, {32'd0, h0});
        rd(3'd4, l, v);
        chk("R9 low kept", {32'd0, l}, {32'd0, l0});
        chk("R9 ovf kept", {63'd0, ovf}, {63'd0, o0});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unsigned();
        t_signed();
        t_lowform();
        t_stall();
        t_hold();
        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule